// File: doc/BRIEF.md
# ALU Status Flag Register

This block computes and holds the condition flags of an 8-bit processor datapath. The surrounding ALU reports, once per cycle, which class of operation it carried out (add, subtract, logic, rotate left or right through carry, or nothing). It also reports both operands, its result and the incoming carry. From these the block derives the carry, half-carry, zero and overflow flags and registers them. In subtraction the carry and half-carry mean "no borrow".

Two power-management flags sit beside the arithmetic flags. A power-down flag records that a halt instruction ran. A time-out flag records that the watchdog expired. Both are driven only by the halt strobe, the watchdog-clear strobe, the watchdog time-out pulse and power-up reset. Software may load the four arithmetic flags directly, but it cannot write the two power flags. Nothing here is saved automatically on interrupt entry or on a call. Firmware that needs the flags preserved must save them itself.

Top module: `stflag_reg`

## Requirements
- R1: While `rst_n` is low, all six flags read 0.
- R2: Operation code 1 (add) computes `a + b + cin`. Carry (bit 0) takes the carry out of bit 7. Half-carry (bit 1) takes the carry out of bit 3.
- R3: Operation code 2 (subtract) computes `a + ~b + cin`, where `cin = 1` means no incoming borrow. Carry is set when no borrow leaves bit 7. Half-carry is set when no borrow passes from the high nibble into the low nibble.
- R4: For codes 1, 2 and 3, zero (bit 2) is set exactly when `res_i` is 0.
- R5: For codes 1 and 2, overflow (bit 3) is set when the carry into bit 7 differs from the carry out of bit 7. For two's-complement operands this is a signed overflow.
- R6: Code 3 (logic) leaves carry, half-carry and overflow unchanged.
- R7: Code 4 (rotate left through carry) loads carry with `opa_i[7]`. Code 5 (rotate right through carry) loads carry with `opa_i[0]`. Both leave half-carry, zero and overflow unchanged.
- R8: Codes 0, 6 and 7 leave the four arithmetic flags unchanged.
- R9: `wr_en_i` loads bits 3:0 from `wr_data_i` in the next cycle and takes precedence over an ALU update in the same cycle. A write never changes bits 5:4.
- R10: The power-down flag (bit 4) is set by `halt_i` and cleared by `wdt_clr_i`. When both occur in the same cycle, halt wins.
- R11: The time-out flag (bit 5) is set by `wdt_to_i` and cleared by `wdt_clr_i` or `halt_i`. When the set and a clear occur in the same cycle, the time-out wins.
- R12: A power-management event and an ALU update in the same cycle both take effect, each on its own bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-up reset |
| op_i | input | 3 | ALU operation class code |
| opa_i | input | 8 | First operand |
| opb_i | input | 8 | Second operand |
| res_i | input | 8 | ALU result |
| cin_i | input | 1 | Carry in (no-borrow for subtract) |
| wr_en_i | input | 1 | Software write strobe |
| wr_data_i | input | 4 | Write data: {overflow, zero, half-carry, carry} |
| wdt_clr_i | input | 1 | Watchdog-clear instruction strobe |
| halt_i | input | 1 | Halt instruction strobe |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| flags_o | output | 6 | {time-out, power-down, overflow, zero, half-carry, carry} |

## Verification
The bench targets subtraction cases where the operands are equal, where the borrow crosses only the nibble boundary, and where the incoming borrow alone causes the borrow. A design that used true borrow polarity would invert carry and half-carry in each of these cases. Signed overflow is driven with 0x7F+0x01 and 0x80-0x01, where an overflow equation built from the wrong carry pair would stay low. Simultaneous strobes (halt with watchdog clear, time-out with clear, a write alongside an ALU operation, a power event alongside an ALU operation) expose wrong precedence or a lost update on one of the bit groups.

// File: rtl/stflag_pkg.sv
package stflag_pkg;
  typedef enum logic [2:0] {
    OPK_IDLE  = 3'd0,
    OPK_ADD   = 3'd1,
    OPK_SUB   = 3'd2,
    OPK_LOGIC = 3'd3,
    OPK_RLC   = 3'd4,
    OPK_RRC   = 3'd5
  } op_kind_e;

  typedef struct packed {
    logic ovf;
    logic zero;
    logic half;
    logic carry;
  } arith_flags_t;

  localparam int ARITH_BITS = 4;
  localparam int FLAG_BITS  = 6;
endpackage

// File: rtl/stflag_calc.sv
module stflag_calc
  import stflag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [2:0]   op_i,
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic [W-1:0] res_i,
  input  logic         cin_i,
  input  arith_flags_t cur_i,
  output arith_flags_t nxt_o
);
  localparam int H = W / 2;

  // returns {overflow, half carry, carry} of a + b + ci
  function automatic logic [2:0] carry_chain(input logic [W-1:0] a,
                                             input logic [W-1:0] b,
                                             input logic ci);
    logic [W:0]   full;
    logic [H:0]   low;
    logic [W-1:0] below;
    full  = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, ci};
    low   = {1'b0, a[H-1:0]} + {1'b0, b[H-1:0]} + {{H{1'b0}}, ci};
    below = {1'b0, a[W-2:0]} + {1'b0, b[W-2:0]} + {{(W-1){1'b0}}, ci};
    return {below[W-1] ^ full[W], low[H], full[W]};
  endfunction

  logic [2:0] add_chain;
  logic [2:0] sub_chain;
  logic       res_is_zero;

  assign add_chain   = carry_chain(opa_i, opb_i, cin_i);
  assign sub_chain   = carry_chain(opa_i, ~opb_i, cin_i);
  assign res_is_zero = (res_i == '0);

  always_comb begin
    nxt_o = cur_i;
    case (op_i)
      OPK_ADD: begin
        nxt_o.carry = add_chain[0];
        nxt_o.half  = add_chain[1];
        nxt_o.ovf   = add_chain[2];
        nxt_o.zero  = res_is_zero;
      end
      OPK_SUB: begin
        nxt_o.carry = sub_chain[0];
        nxt_o.half  = sub_chain[1];
        nxt_o.ovf   = sub_chain[2];
        nxt_o.zero  = res_is_zero;
      end
      OPK_LOGIC: nxt_o.zero  = res_is_zero;
      OPK_RLC:   nxt_o.carry = opa_i[W-1];
      OPK_RRC:   nxt_o.carry = opa_i[0];
      default:   nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/stflag_pm.sv
module stflag_pm (
  input  logic clk,
  input  logic rst_n,
  input  logic wdt_clr_i,
  input  logic halt_i,
  input  logic wdt_to_i,
  output logic pd_o,
  output logic to_o
);
  logic pd_set, pd_clr, to_set, to_clr;

  assign pd_set = halt_i;
  assign pd_clr = wdt_clr_i;
  assign to_set = wdt_to_i;
  assign to_clr = wdt_clr_i | halt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pd_o <= 1'b0;
      to_o <= 1'b0;
    end else begin
      if (pd_set)      pd_o <= 1'b1;
      else if (pd_clr) pd_o <= 1'b0;
      if (to_set)      to_o <= 1'b1;
      else if (to_clr) to_o <= 1'b0;
    end
  end

  AST_HALT_SETS_PD: assert property (@(posedge clk) disable iff (!rst_n)
    halt_i |=> pd_o); // R10
  AST_CLR_DROPS_PD: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr_i && !halt_i) |=> !pd_o); // R10
  AST_TMO_SETS_TO: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_to_i |=> to_o); // R11
  AST_CLR_DROPS_TO: assert property (@(posedge clk) disable iff (!rst_n)
    ((wdt_clr_i || halt_i) && !wdt_to_i) |=> !to_o); // R11
endmodule

// File: rtl/stflag_reg.sv
module stflag_reg
  import stflag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            op_i,
  input  logic [W-1:0]          opa_i,
  input  logic [W-1:0]          opb_i,
  input  logic [W-1:0]          res_i,
  input  logic                  cin_i,
  input  logic                  wr_en_i,
  input  logic [ARITH_BITS-1:0] wr_data_i,
  input  logic                  wdt_clr_i,
  input  logic                  halt_i,
  input  logic                  wdt_to_i,
  output logic [FLAG_BITS-1:0]  flags_o
);
  arith_flags_t arith_q, arith_nxt;
  logic         pd_q, to_q;
  logic         alu_upd;

  stflag_calc #(.W(W)) u_calc (
    .op_i (op_i), .opa_i(opa_i), .opb_i(opb_i), .res_i(res_i),
    .cin_i(cin_i), .cur_i(arith_q), .nxt_o(arith_nxt)
  );

  stflag_pm u_pm (
    .clk(clk), .rst_n(rst_n), .wdt_clr_i(wdt_clr_i), .halt_i(halt_i),
    .wdt_to_i(wdt_to_i), .pd_o(pd_q), .to_o(to_q)
  );

  assign alu_upd = !wr_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       arith_q <= '0;
    else if (wr_en_i) arith_q <= arith_flags_t'(wr_data_i);
    else if (alu_upd) arith_q <= arith_nxt;
  end

  assign flags_o = {to_q, pd_q, arith_q};

  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> (flags_o == '0)); // R1
  AST_ADD_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OPK_ADD && !wr_en_i) |=>
      flags_o[0] == $past(({1'b0, opa_i} + {1'b0, opb_i} + {{W{1'b0}}, cin_i}) >> W)); // R2
  AST_ZERO_FROM_RES: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OPK_ADD || op_i == OPK_SUB || op_i == OPK_LOGIC) && !wr_en_i) |=>
      flags_o[2] == $past(res_i == '0)); // R4
  AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OPK_LOGIC && !wr_en_i) |=>
      ($stable(flags_o[0]) && $stable(flags_o[1]) && $stable(flags_o[3]))); // R6
  AST_ROTL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OPK_RLC && !wr_en_i) |=> flags_o[0] == $past(opa_i[W-1])); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OPK_IDLE || op_i > OPK_RRC) && !wr_en_i) |=> $stable(flags_o[3:0])); // R8
  AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> flags_o[3:0] == $past(wr_data_i)); // R9
endmodule

// File: tb/sim_stflag_reg.sv
`timescale 1ns/1ps
module sim_stflag_reg;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op = 3'd0;
  logic [7:0] a = 8'd0, b = 8'd0, res = 8'd0;
  logic       cin = 1'b0, wr = 1'b0, clr = 1'b0, hlt = 1'b0, tmo = 1'b0;
  logic [3:0] wd = 4'd0;
  logic [5:0] flags;
  logic [5:0] exp_f = 6'd0;
  int total = 0, bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  stflag_reg #(.W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_i(op), .opa_i(a), .opb_i(b), .res_i(res),
    .cin_i(cin), .wr_en_i(wr), .wr_data_i(wd), .wdt_clr_i(clr),
    .halt_i(hlt), .wdt_to_i(tmo), .flags_o(flags)
  );

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  // sum of a, b' and cin as plain integers; signed overflow by sign comparison
  function automatic logic [3:0] model(input logic [2:0] o, input int x, input int y,
                                       input int r, input int ci, input logic [3:0] cur);
    logic [3:0] f;
    int yy, s, c, hc, v;
    f = cur;
    if (o == 3'd1 || o == 3'd2) begin
      yy = (o == 3'd2) ? 255 - y : y;
      s  = x + yy + ci;
      c  = (s > 255) ? 1 : 0;
      hc = (((x % 16) + (yy % 16) + ci) > 15) ? 1 : 0;
      v  = ((x >= 128) == (yy >= 128)) && (((s % 256) >= 128) != (x >= 128)) ? 1 : 0;
      f  = {v[0], (r == 0), hc[0], c[0]};
    end else if (o == 3'd3) f[2] = (r == 0);
    else if (o == 3'd4) f[0] = (x >= 128);
    else if (o == 3'd5) f[0] = (x % 2 == 1);
    return f;
  endfunction

  task automatic step(input string req, input logic [2:0] o, input logic [7:0] x,
                      input logic [7:0] y, input logic ci, input logic w,
                      input logic [3:0] wdat, input logic c_s, input logic h_s,
                      input logic t_s);
    int r;
    @(negedge clk);
    if (o == 3'd1) r = (x + y + ci) % 256;
    else if (o == 3'd2) r = (x + 255 - y + ci) % 256;
    else r = x & y;
    op = o; a = x; b = y; cin = ci; res = r[7:0]; wr = w; wd = wdat;
    clr = c_s; hlt = h_s; tmo = t_s;
    exp_f[3:0] = w ? wdat : model(o, x, y, r, ci, exp_f[3:0]);
    if (h_s) exp_f[4] = 1'b1; else if (c_s) exp_f[4] = 1'b0;
    if (t_s) exp_f[5] = 1'b1; else if (c_s || h_s) exp_f[5] = 1'b0;
    @(negedge clk);
    op = 3'd0; wr = 1'b0; clr = 1'b0; hlt = 1'b0; tmo = 1'b0;
    chk(req, flags, exp_f);
  endtask

  task automatic t_reset();
    chk("R1 reset", flags, 6'd0);
  endtask

  task automatic t_add();
    step("R2 add 0x0F+0x01", 3'd1, 8'h0F, 8'h01, 0, 0, 0, 0, 0, 0);
    step("R2 add carry out", 3'd1, 8'hF0, 8'h20, 0, 0, 0, 0, 0, 0);
    step("R4 add zero result", 3'd1, 8'hFF, 8'h00, 1, 0, 0, 0, 0, 0);
    step("R5 add signed ovf", 3'd1, 8'h7F, 8'h01, 0, 0, 0, 0, 0, 0);
    step("R5 add neg ovf", 3'd1, 8'h80, 8'h80, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_sub();
    step("R3 sub equal", 3'd2, 8'h55, 8'h55, 1, 0, 0, 0, 0, 0);
    step("R3 sub nibble borrow", 3'd2, 8'h30, 8'h01, 1, 0, 0, 0, 0, 0);
    step("R3 sub full borrow", 3'd2, 8'h01, 8'h02, 1, 0, 0, 0, 0, 0);
    step("R3 sub borrow in", 3'd2, 8'h40, 8'h40, 0, 0, 0, 0, 0, 0);
    step("R5 sub signed ovf", 3'd2, 8'h80, 8'h01, 1, 0, 0, 0, 0, 0);
  endtask

  task automatic t_logic();
    step("R4 logic nonzero", 3'd3, 8'hF0, 8'h3C, 0, 0, 0, 0, 0, 0);
    step("R6 logic zero keeps", 3'd3, 8'hF0, 8'h0F, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_rotate();
    step("R7 rotl bit7=1", 3'd4, 8'h81, 8'h00, 0, 0, 0, 0, 0, 0);
    step("R7 rotr bit0=0", 3'd5, 8'h81 ^ 8'h01, 8'h00, 0, 0, 0, 0, 0, 0);
    step("R7 rotr bit0=1", 3'd5, 8'h03, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_idle();
    step("R8 idle code0", 3'd0, 8'hFF, 8'hFF, 1, 0, 0, 0, 0, 0);
    step("R8 idle code6", 3'd6, 8'hFF, 8'h01, 1, 0, 0, 0, 0, 0);
    step("R8 idle code7", 3'd7, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_write();
    step("R9 write pattern", 3'd0, 8'h00, 8'h00, 0, 1, 4'b1010, 0, 0, 0);
    step("R9 write beats add", 3'd1, 8'hFF, 8'h01, 0, 1, 4'b0101, 0, 0, 0);
  endtask

  task automatic t_power();
    step("R10 halt sets pd", 3'd0, 0, 0, 0, 0, 0, 0, 1, 0);
    step("R11 tmo sets to", 3'd0, 0, 0, 0, 0, 0, 0, 0, 1);
    step("R9 write keeps pm bits", 3'd0, 0, 0, 0, 1, 4'b0000, 0, 0, 0);
    step("R10 clr drops pd and to", 3'd0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R10 halt wins over clr", 3'd0, 0, 0, 0, 0, 0, 1, 1, 0);
    step("R11 tmo wins over clr", 3'd0, 0, 0, 0, 0, 0, 1, 0, 1);
    step("R11 halt clears to", 3'd0, 0, 0, 0, 0, 0, 0, 1, 0);
  endtask

  task automatic t_concurrent();
    step("R12 add with tmo", 3'd1, 8'h7F, 8'h01, 0, 0, 0, 0, 0, 1);
    step("R12 sub with clr", 3'd2, 8'h10, 8'h10, 1, 0, 0, 1, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_add();
    t_sub();
    t_logic();
    t_rotate();
    t_idle();
    t_write();
    t_power();
    t_concurrent();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    exp_f = 6'd0;
    t_reset();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule